// File: doc/BRIEF.md
# Four-Block Vector Row Memory

This block models the local store of one processing node. The store is split into four blocks, each 32 bits wide. A control processor reaches any single word through a random-access port that sees one flat address space. An arithmetic pipeline reaches the store one whole row at a time, through a shift register attached to each block.

A row is copied into its block's shift register in one cycle. Operands then leave the head of the registers one word per shift. At the same time, results from the pipeline enter the tail of all four registers. A mask chooses which registers are written back into a row, so a result vector can be placed in any block. Block 0 is the small operand bank. Blocks 1 to 3 together form the large bank. One operand comes from each bank on every cycle. A 64-bit element takes two neighbouring words of a row and streams over two shifts.

Each byte carries an even parity bit. The bit is made whenever a word is stored and checked whenever a word is read or a row is loaded. A mismatch raises a sticky interrupt line.

Top module: `vec_row_mem`

## Requirements
- R1: After reset, cp_rdata, cp_rvalid, par_irq, op_a and op_b are all 0, and every memory word reads back as 0 with valid parity.
- R2: cp_addr is {block[1:0], row[RB-1:0], word[WB-1:0]}. A write stores cp_wdata at the edge. A read returns the stored word on cp_rdata after the edge at which it was requested.
- R3: With ld_large=0 and ld_row < ROWS, a load copies row ld_row of block 0 into block 0's register. op_a shows word 0 of that row after the edge.
- R4: With ld_large=1 and ld_row < 3*ROWS, a load copies row ld_row%ROWS of block 1+ld_row/ROWS into that block's register, and op_b then follows that block's register. Loads with ld_row out of range for the chosen bank are ignored, and op_a and op_b keep their values.
- R5: Each cycle with sh_en moves every register one word toward its head (word 0) and puts sh_in into the last word of all four registers. A block being loaded in the same cycle takes the load instead of the shift.
- R6: With wb_en, each block whose wb_mask bit is set writes its whole register, as it was before the edge, into row wb_row of that block. Blocks whose bit is clear keep their contents. A write-back takes priority over a processor write to the same word.
- R7: A processor write to a row whose copy sits in a shift register does not change the register.
- R8: Parity is even per byte: bit k of a word's parity equals the XOR of byte k. A processor read of a word with bad parity, or a load of a row that contains one, sets par_irq after that edge.
- R9: par_irq stays high until a cycle with irq_clr and no new error. A new error in the same cycle as irq_clr keeps it high.
- R10: cp_rvalid is high for exactly the cycle after each read request and low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cp_en | input | 1 | Processor access request |
| cp_we | input | 1 | 1 = write, 0 = read |
| cp_addr | input | AW | Flat word address {block,row,word} |
| cp_wdata | input | 32 | Write data |
| cp_rdata | output | 32 | Read data |
| cp_rvalid | output | 1 | Read data valid |
| ld_en | input | 1 | Load a row into a shift register |
| ld_large | input | 1 | 0 = small bank, 1 = large bank |
| ld_row | input | RB+2 | Row index within the chosen bank |
| sh_en | input | 1 | Shift all registers by one word |
| sh_in | input | 32 | Result word entering all register tails |
| op_a | output | 32 | Head of the small-bank register |
| op_b | output | 32 | Head of the last-loaded large-bank register |
| wb_en | input | 1 | Write registers back |
| wb_mask | input | 4 | Blocks taking part in write-back |
| wb_row | input | RB | Target row in each selected block |
| par_irq | output | 1 | Sticky parity error interrupt |
| irq_clr | input | 1 | Clears par_irq |

## Verification
Every result lands one edge after its request. Read data, cp_rvalid and the parity interrupt all register at that edge. So do the load, shift and write-back effects seen on op_a and op_b. The bench drives inputs on the falling edge, steps its model at the rising edge, and compares all outputs on the next falling edge. Write-back and ignore cases are checked through later processor reads and later operand values, and each such check falls exactly one edge after the access that exposes it.

// File: rtl/vec_row_mem.sv
module vec_row_mem #(
  parameter int ROWS = 4,
  parameter int ROW_WORDS = 8,
  localparam int RB = $clog2(ROWS),
  localparam int WB = $clog2(ROW_WORDS),
  localparam int AW = 2 + RB + WB,
  localparam int NW = 4 * ROWS * ROW_WORDS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cp_en,
  input  logic          cp_we,
  input  logic [AW-1:0] cp_addr,
  input  logic [31:0]   cp_wdata,
  output logic [31:0]   cp_rdata,
  output logic          cp_rvalid,
  input  logic          ld_en,
  input  logic          ld_large,
  input  logic [RB+1:0] ld_row,
  input  logic          sh_en,
  input  logic [31:0]   sh_in,
  output logic [31:0]   op_a,
  output logic [31:0]   op_b,
  input  logic          wb_en,
  input  logic [3:0]    wb_mask,
  input  logic [RB-1:0] wb_row,
  output logic          par_irq,
  input  logic          irq_clr
);

  function automatic logic [3:0] pgen(input logic [31:0] d);
    return {^d[31:24], ^d[23:16], ^d[15:8], ^d[7:0]};
  endfunction

  logic [35:0] mem_q [NW];
  logic [31:0] sreg_q [4][ROW_WORDS];
  logic [1:0]  bsel_q;

  wire [1:0]    ld_hi  = ld_row[RB+1:RB];
  wire [1:0]    ld_blk = ld_large ? 2'(ld_hi + 2'd1) : 2'd0;
  wire [RB-1:0] ld_r   = ld_row[RB-1:0];
  wire          ld_ok  = ld_en & (ld_large ? (ld_hi != 2'd3) : (ld_hi == 2'd0));
  wire          rd_req = cp_en & ~cp_we;
  wire [35:0]   rd_ent = mem_q[cp_addr];
  wire          rd_bad = rd_req & (pgen(rd_ent[31:0]) != rd_ent[35:32]);

  logic        ld_bad;
  logic [35:0] ld_ent;
  always_comb begin
    ld_bad = 1'b0;
    ld_ent = '0;
    for (int w = 0; w < ROW_WORDS; w++) begin
      ld_ent = mem_q[{ld_blk, ld_r, WB'(w)}];
      if (pgen(ld_ent[31:0]) != ld_ent[35:32]) ld_bad = 1'b1;
    end
  end

  assign op_a = sreg_q[0][0];
  assign op_b = sreg_q[bsel_q][0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mem_q[i] <= '0;
      for (int b = 0; b < 4; b++)
        for (int w = 0; w < ROW_WORDS; w++) sreg_q[b][w] <= '0;
      cp_rdata  <= '0;
      cp_rvalid <= 1'b0;
      par_irq   <= 1'b0;
      bsel_q    <= 2'd1;
    end else begin
      cp_rvalid <= rd_req;
      if (rd_req) cp_rdata <= rd_ent[31:0];
      if (cp_en && cp_we) mem_q[cp_addr] <= {pgen(cp_wdata), cp_wdata};
      if (wb_en)
        for (int b = 0; b < 4; b++)
          if (wb_mask[b])
            for (int w = 0; w < ROW_WORDS; w++)
              mem_q[{2'(b), wb_row, WB'(w)}] <= {pgen(sreg_q[b][w]), sreg_q[b][w]};
      for (int b = 0; b < 4; b++) begin
        if (ld_ok && ld_blk == 2'(b)) begin
          for (int w = 0; w < ROW_WORDS; w++)
            sreg_q[b][w] <= mem_q[{ld_blk, ld_r, WB'(w)}][31:0];
        end else if (sh_en) begin
          for (int w = 0; w < ROW_WORDS - 1; w++) sreg_q[b][w] <= sreg_q[b][w+1];
          sreg_q[b][ROW_WORDS-1] <= sh_in;
        end
      end
      if (ld_ok && ld_large) bsel_q <= ld_blk;
      if (rd_bad || (ld_ok && ld_bad)) par_irq <= 1'b1;
      else if (irq_clr) par_irq <= 1'b0;
    end
  end

endmodule

// File: rtl/vec_row_mem_chk.sv
module vec_row_mem_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cp_en,
  input logic        cp_we,
  input logic        cp_rvalid,
  input logic        ld_en,
  input logic        sh_en,
  input logic [31:0] op_a,
  input logic [31:0] op_b,
  input logic        par_irq,
  input logic        irq_clr
);

  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (cp_en && !cp_we) |=> cp_rvalid); // R10
  AST_NO_RVALID_OTHERWISE: assert property (@(posedge clk) disable iff (!rst_n)
    !(cp_en && !cp_we) |=> !cp_rvalid); // R10
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (par_irq && !irq_clr) |=> par_irq); // R9
  AST_IRQ_FALL_NEEDS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(par_irq) |-> $past(irq_clr)); // R9
  AST_OPS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_en && !ld_en) |=> ($stable(op_a) && $stable(op_b))); // R5

endmodule

bind vec_row_mem vec_row_mem_chk u_chk (.*);

// File: tb/sim_vec_row_mem.sv
`timescale 1ns/1ps
module sim_vec_row_mem;
  localparam int ROWS = 4, RW = 8, RB = 2, AW = 7, NW = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cp_en = 0, cp_we = 0, ld_en = 0, ld_large = 0, sh_en = 0, wb_en = 0, irq_clr = 0;
  logic [AW-1:0] cp_addr = '0;
  logic [31:0] cp_wdata = '0, sh_in = '0;
  logic [RB+1:0] ld_row = '0;
  logic [3:0] wb_mask = '0;
  logic [RB-1:0] wb_row = '0;
  logic [31:0] cp_rdata, op_a, op_b;
  logic cp_rvalid, par_irq;

  vec_row_mem u0 (.clk(clk), .rst_n(rst_n), .cp_en(cp_en), .cp_we(cp_we), .cp_addr(cp_addr),
    .cp_wdata(cp_wdata), .cp_rdata(cp_rdata), .cp_rvalid(cp_rvalid), .ld_en(ld_en),
    .ld_large(ld_large), .ld_row(ld_row), .sh_en(sh_en), .sh_in(sh_in), .op_a(op_a),
    .op_b(op_b), .wb_en(wb_en), .wb_mask(wb_mask), .wb_row(wb_row), .par_irq(par_irq),
    .irq_clr(irq_clr));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] m_mem [NW];
  bit          m_bad [NW];
  logic [31:0] m_sr [4][RW];
  logic [1:0]  m_bsel = 2'd1;
  logic        m_irq = 0, m_rv = 0;
  logic [31:0] m_rd = '0;

  function automatic logic [3:0] par4(input logic [31:0] d);
    return {^d[31:24], ^d[23:16], ^d[15:8], ^d[7:0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    cp_en = 0; cp_we = 0; ld_en = 0; sh_en = 0; wb_en = 0; irq_clr = 0;
  endtask

  task automatic tick();
    logic [31:0] row [RW];
    logic lbad, ok, rdbad;
    logic [1:0] hi, blk;
    logic [AW-1:0] ix;
    hi = ld_row[RB+1:RB];
    blk = ld_large ? 2'(hi + 2'd1) : 2'd0;
    ok = ld_en && (ld_large ? (hi != 2'd3) : (hi == 2'd0));
    lbad = 0;
    for (int w = 0; w < RW; w++) begin
      ix = {blk, ld_row[RB-1:0], 3'(w)};
      row[w] = m_mem[ix];
      if (m_bad[ix]) lbad = 1;
    end
    m_rv = cp_en && !cp_we;
    rdbad = m_rv && m_bad[cp_addr];
    if (m_rv) m_rd = m_mem[cp_addr];
    if (cp_en && cp_we) begin m_mem[cp_addr] = cp_wdata; m_bad[cp_addr] = 0; end
    if (wb_en)
      for (int b = 0; b < 4; b++)
        if (wb_mask[b])
          for (int w = 0; w < RW; w++) begin
            ix = {2'(b), wb_row, 3'(w)};
            m_mem[ix] = m_sr[b][w]; m_bad[ix] = 0;
          end
    for (int b = 0; b < 4; b++) begin
      if (ok && blk == 2'(b)) begin
        for (int w = 0; w < RW; w++) m_sr[b][w] = row[w];
      end else if (sh_en) begin
        for (int w = 0; w < RW - 1; w++) m_sr[b][w] = m_sr[b][w+1];
        m_sr[b][RW-1] = sh_in;
      end
    end
    if (ok && ld_large) m_bsel = blk;
    if (rdbad || (ok && lbad)) m_irq = 1;
    else if (irq_clr) m_irq = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R10", "rvalid", 32'(cp_rvalid), 32'(m_rv));
    if (m_rv) chk("R2", "rdata", cp_rdata, m_rd);
    chk("R5", "op_a", op_a, m_sr[0][0]);
    chk("R4", "op_b", op_b, m_sr[m_bsel][0]);
    chk("R9", "irq", 32'(par_irq), 32'(m_irq));
    idle();
  endtask

  task automatic cpw(input logic [AW-1:0] a, input logic [31:0] d);
    cp_en = 1; cp_we = 1; cp_addr = a; cp_wdata = d; tick();
  endtask

  task automatic cpr(input logic [AW-1:0] a);
    cp_en = 1; cp_we = 0; cp_addr = a; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] keep_a, keep_b;
    logic [AW-1:0] ix;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NW; i++) begin m_mem[i] = '0; m_bad[i] = 0; end
    for (int b = 0; b < 4; b++) for (int w = 0; w < RW; w++) m_sr[b][w] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1", "rdata", cp_rdata, 32'h0);
    chk("R1", "rvalid", 32'(cp_rvalid), 32'h0);
    chk("R1", "op_a", op_a, 32'h0);
    chk("R1", "op_b", op_b, 32'h0);
    chk("R1", "irq", 32'(par_irq), 32'h0);
    cpr(7'h55);
    chk("R1", "mem after reset", cp_rdata, 32'h0);

    // R3 directed: fill block 0 row 1, load it
    for (int w = 0; w < RW; w++) cpw({2'd0, 2'd1, 3'(w)}, 32'hA000_0000 + 32'(w));
    ld_en = 1; ld_large = 0; ld_row = 4'd1; tick();
    chk("R3", "op_a after load", op_a, 32'hA000_0000);
    // R7: write into the loaded row, register keeps old copy
    cpw({2'd0, 2'd1, 3'd0}, 32'hDEAD_BEEF);
    chk("R7", "op_a after cpu write", op_a, 32'hA000_0000);
    cpr({2'd0, 2'd1, 3'd0});
    chk("R2", "cpu readback", cp_rdata, 32'hDEAD_BEEF);
    // R4: large bank row 9 -> block 3 row 1
    for (int w = 0; w < RW; w++) cpw({2'd3, 2'd1, 3'(w)}, 32'hB300_0000 + 32'(w));
    ld_en = 1; ld_large = 1; ld_row = 4'd9; tick();
    chk("R4", "op_b block3", op_b, 32'hB300_0000);
    keep_a = op_a; keep_b = op_b;
    ld_en = 1; ld_large = 1; ld_row = 4'd12; tick();
    chk("R4", "large out of range", op_b, keep_b);
    ld_en = 1; ld_large = 0; ld_row = 4'd5; tick();
    chk("R4", "small out of range", op_a, keep_a);
    // R5: shift three times
    for (int k = 0; k < 3; k++) begin sh_en = 1; sh_in = 32'hC0DE_0000 + 32'(k); tick(); end
    chk("R5", "op_a after 3 shifts", op_a, 32'hA000_0003);
    chk("R5", "op_b after 3 shifts", op_b, 32'hB300_0003);
    // R6: write-back mask 0101 into row 2, racing a cpu write to block 0 row 2 word 0
    wb_en = 1; wb_mask = 4'b0101; wb_row = 2'd2;
    cp_en = 1; cp_we = 1; cp_addr = {2'd0, 2'd2, 3'd0}; cp_wdata = 32'h1111_2222; tick();
    cpr({2'd0, 2'd2, 3'd0});
    chk("R6", "wb beats cpu write", cp_rdata, 32'hA000_0003);
    cpr({2'd0, 2'd2, 3'd7});
    chk("R6", "wb tail word", cp_rdata, 32'hC0DE_0002);
    cpr({2'd1, 2'd2, 3'd0});
    chk("R6", "masked-off block", cp_rdata, 32'h0);

    // random mix
    for (int n = 0; n < 800; n++) begin
      cp_en = 1'($urandom); cp_we = 1'($urandom); cp_addr = AW'($urandom); cp_wdata = $urandom;
      ld_en = ($urandom % 4 == 0); ld_large = 1'($urandom); ld_row = 4'($urandom);
      sh_en = 1'($urandom); sh_in = $urandom;
      wb_en = ($urandom % 5 == 0); wb_mask = 4'($urandom); wb_row = 2'($urandom);
      tick();
    end

    // R8: corrupt a stored word (parity no longer matches), read it
    ix = {2'd2, 2'd3, 3'd5};
    cpw(ix, 32'h0F0F_3C3C);
    u0.mem_q[ix] <= {par4(32'h0F0F_3C3C) ^ 4'h2, 32'h0F0F_3C3C};
    m_bad[ix] = 1;
    cpr({2'd2, 2'd3, 3'd4});
    chk("R8", "clean read no irq", 32'(par_irq), 32'h0);
    cpr(ix);
    chk("R8", "bad read irq", 32'(par_irq), 32'h1);
    tick();
    chk("R9", "irq held", 32'(par_irq), 32'h1);
    irq_clr = 1; tick();
    chk("R9", "irq cleared", 32'(par_irq), 32'h0);
    // load of row with bad word: large index 7 -> block 2 row 3
    ld_en = 1; ld_large = 1; ld_row = 4'd7; tick();
    chk("R8", "bad row load irq", 32'(par_irq), 32'h1);
    ld_en = 1; ld_large = 1; ld_row = 4'd7; irq_clr = 1; tick();
    chk("R9", "set beats clear", 32'(par_irq), 32'h1);
    cpw(ix, 32'h1234_5678);
    irq_clr = 1; tick();
    cpr(ix);
    chk("R8", "rewrite restores parity", 32'(par_irq), 32'h0);
    chk("R2", "rewrite data", cp_rdata, 32'h1234_5678);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule